// File: doc/BRIEF.md
# SPI Master/Slave Byte Controller

This block is an 8-bit serial peripheral interface controller for a small microcontroller. Software reaches it through a byte-wide register bus with three locations: control, status and data. A control bit picks master or slave operation; clock polarity and clock phase are programmable, and in master mode a three-bit rate code divides the peripheral clock by a power of two between 2 and 128 to make SCK.

A single 8-bit shift register carries each byte. Writing the data location while an idle master starts eight SCK cycles that send the written byte MSB first on MOSI and collect a byte from MISO. In slave mode, writing the data location between bytes preloads the reply, and the remote master's SCK moves bits the other way. When a byte finishes, the received value becomes readable at the data location and a completion flag in the status location is raised. Software clears the flag by reading the status location while the flag is set, followed by any access to the data location.

The register bus has no back-pressure: every strobe is taken in the cycle it is presented, and the read data is a combinational function of the address. The serial pins are plain levels with separate output-enable signals. Slave-side inputs pass through two-stage synchronizers, so the remote SCK must stay in each level for several peripheral clocks.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control and status locations read 0x00, SCK is low, and all three output enables (sck_oe, mosi_oe, miso_oe) are low while ss_n_i is high.
- R2: The control location (address 0) stores all 8 written bits and reads them back; field layout: bits [2:0] rate code, bit 3 phase, bit 4 polarity, bit 5 master select (1 = master, 0 = slave), bit 6 select-disable, bit 7 spare.
- R3: In master mode each SCK level lasts 2^code peripheral clocks for rate codes 0 to 6 (SCK = clock / 2^(code+1)); code 7 behaves as code 6 (divide by 128).
- R4: An idle master holds SCK at the polarity bit; a master transfer produces exactly 16 SCK edges and leaves SCK back at the polarity level.
- R5: With phase 0 the master presents the first bit before the first edge, samples MISO on leading edges and changes MOSI on trailing edges; bytes move MSB first in both directions.
- R6: With phase 1 the master changes MOSI on leading edges and samples MISO on trailing edges, MSB first.
- R7: Status bit 7 rises when a byte completes; it is cleared only by a status read made while it is set, followed by a data access (read or write); a data access without that status read leaves it set.
- R8: A data write while a master transfer is running is ignored: the byte in flight and the edge count are unaffected.
- R9: A slave with select enabled exchanges a byte with the remote master only while ss_n_i is low, and enables its MISO driver only while selected.
- R10: A phase-0 slave drives the MSB of its reply on MISO as soon as it is selected, before the first SCK edge.
- R11: With phase 1 and select-disable set, a slave transfers bytes with ss_n_i held high.
- R12: With phase 0, select-disable has no effect: a slave with ss_n_i high ignores SCK, sets no flag and keeps its MISO driver off.
- R13: Reading the data location (address 2) returns the byte most recently received; the status location is address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status and data reads have side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed location |
| sck_o | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable (master mode) |
| sck_i | input | 1 | SCK received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_oe | output | 1 | MOSI output enable (master mode) |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | MISO output enable (selected slave) |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench runs master transfers in all four polarity/phase combinations against a behavioural slave, so a design that sampled on the launch edge would return a byte shifted by one bit, and one with a wrong idle level would show a seventeenth edge or a stuck SCK. Half-period measurement at rate codes 0, 3 and 7 catches an off-by-one divider or a code 7 that wraps to a fast rate. The flag sequence is probed with a data read taken before the status read, which a design that clears on any data access would wrongly honour, and a second data write during a busy transfer would corrupt the byte a careless design sends. Slave runs cover the phase-0 MSB shown before any edge, select-disable honoured under phase 1, and select-disable wrongly honoured under phase 0, which would raise the flag and overwrite the received byte.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int RATE_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DATA = 2'd2;

  // Control register layout, MSB first.
  typedef struct packed {
    logic              spare;
    logic              sel_off;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_W  = 3,
  parameter int MAX_EXP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [RATE_W-1:0] eff;
  logic [CNT_W:0]    half;
  logic [CNT_W-1:0]  cnt;

  // Codes above the largest exponent saturate at it.
  assign eff  = (rate > RATE_W'(MAX_EXP)) ? RATE_W'(MAX_EXP) : rate;
  assign half = (CNT_W+1)'(1) << eff;
  assign tick = run && ((CNT_W+1)'(cnt) == (half - (CNT_W+1)'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != '0 && tick) |=> !tick);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              restart,
  input  logic              preload,
  input  logic              sample,
  input  logic              launch,
  input  logic              din,
  output logic              out_bit,
  output logic              at_start,
  output logic              byte_done,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              out_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        sh    <= load_data;
        cnt   <= '0;
        out_q <= load_data[DATA_W-1];
      end else if (restart) begin
        cnt <= '0;
        if (preload) out_q <= sh[DATA_W-1];
      end else begin
        if (launch)                   out_q <= sh[DATA_W-1];
        else if (preload && cnt == '0) out_q <= sh[DATA_W-1];
        if (sample) begin
          sh <= {sh[DATA_W-2:0], din};
          if (cnt == LAST) begin
            cnt    <= '0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign out_bit   = out_q;
  assign at_start  = (cnt == '0);
  assign byte_done = done_q;
  assign word      = sh;

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample, launch}));
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int MAX_EXP     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  input  logic              ss_n_i
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  ctrl_t             ctrl_q;
  logic              flag_q, armed_q;
  logic [DATA_W-1:0] rx_q;

  logic              data_wr, data_acc, stat_rd;
  logic              m_busy, sck_q, tick, start, m_leading;
  logic [EDGE_W-1:0] edge_idx;

  logic              sck_s, mosi_s, ss_s, sck_prev;
  logic              s_edge, s_leading, sel, slave_act;

  logic              eng_load, eng_restart, eng_sample, eng_launch, eng_din;
  logic              out_bit, at_start, byte_done;
  logic [DATA_W-1:0] word;

  // ---------------- register access ----------------
  assign data_wr  = reg_wr && (reg_addr == ADR_DATA);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADR_DATA);
  assign stat_rd  = reg_rd && (reg_addr == ADR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_q    <= '0;
    end else if (byte_done) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
      rx_q    <= word;
    end else if (stat_rd && flag_q) begin
      armed_q <= 1'b1;
    end else if (armed_q && data_acc) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = ctrl_q;
      ADR_STAT: reg_rdata = {flag_q, {(DATA_W-1){1'b0}}};
      ADR_DATA: reg_rdata = rx_q;
      default:  reg_rdata = '0;
    endcase
  end

  // ---------------- master sequencer ----------------
  spi_rate_gen #(.RATE_W(RATE_W), .MAX_EXP(MAX_EXP)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (m_busy),
    .rate (ctrl_q.rate),
    .tick (tick)
  );

  assign start     = data_wr && ctrl_q.master && !m_busy;
  assign m_leading = ~edge_idx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy   <= 1'b0;
      edge_idx <= '0;
      sck_q    <= 1'b0;
    end else if (m_busy) begin
      if (tick) begin
        sck_q <= ~sck_q;
        if (edge_idx == LAST_EDGE) begin
          m_busy   <= 1'b0;
          edge_idx <= '0;
        end else begin
          edge_idx <= edge_idx + EDGE_W'(1);
        end
      end
    end else begin
      sck_q <= ctrl_q.cpol;
      if (start) begin
        m_busy   <= 1'b1;
        edge_idx <= '0;
      end
    end
  end

  // ---------------- slave front end ----------------
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign s_edge    = sck_s ^ sck_prev;
  assign s_leading = sck_s ^ ctrl_q.cpol;
  // Select may be bypassed only when phase is 1.
  assign sel       = (ctrl_q.sel_off && ctrl_q.cpha) || !ss_s;
  assign slave_act = !ctrl_q.master && sel;

  // ---------------- shared shift path ----------------
  always_comb begin
    if (ctrl_q.master) begin
      eng_sample = m_busy && tick && (m_leading ^ ctrl_q.cpha);
      eng_launch = m_busy && tick && !(m_leading ^ ctrl_q.cpha);
      eng_din    = miso_i;
      eng_load   = data_wr && !m_busy;
    end else begin
      eng_sample = slave_act && s_edge && (s_leading ^ ctrl_q.cpha);
      eng_launch = slave_act && s_edge && !(s_leading ^ ctrl_q.cpha);
      eng_din    = mosi_s;
      eng_load   = data_wr && at_start;
    end
  end
  assign eng_restart = !ctrl_q.master && !sel;

  spi_bit_engine #(.DATA_W(DATA_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (eng_load),
    .load_data(reg_wdata),
    .restart  (eng_restart),
    .preload  (!ctrl_q.cpha),
    .sample   (eng_sample),
    .launch   (eng_launch),
    .din      (eng_din),
    .out_bit  (out_bit),
    .at_start (at_start),
    .byte_done(byte_done),
    .word     (word)
  );

  assign sck_o   = sck_q;
  assign sck_oe  = ctrl_q.master;
  assign mosi_o  = out_bit;
  assign mosi_oe = ctrl_q.master;
  assign miso_o  = out_bit;
  assign miso_oe = slave_act;

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.master && !m_busy && $past(!m_busy) && $stable(ctrl_q)) |-> (sck_o == ctrl_q.cpol));

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(byte_done));

  // R12
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_restart |=> !byte_done);
endmodule

// File: tb/sim_spi_ctl.sv
module sim_spi_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, miso_i;

  int n_chk = 0, n_fail = 0;
  localparam int SHALF = 8;

  always #4 clk = ~clk;

  spi_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  // Behavioural slave used while the design is master.
  logic       bm_en = 1'b0, bm_cpol = 1'b0, bm_cpha = 1'b0, bm_prev = 1'b0, bm_out = 1'b0;
  logic [7:0] bm_tx = 8'd0, bm_rx = 8'd0;
  int         bm_edges = 0;
  assign miso_i = bm_out;

  always @(negedge clk) begin
    if (bm_en && sck_o !== bm_prev) begin
      bm_edges++;
      if ((sck_o != bm_cpol) ^ bm_cpha) bm_rx = {bm_rx[6:0], mosi_o};
      else begin
        bm_out = bm_tx[7];
        bm_tx  = {bm_tx[6:0], 1'b0};
      end
      bm_prev = sck_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] cw(input logic off, input logic mst, input logic pol,
                                    input logic pha, input logic [2:0] rate);
    return {1'b0, off, mst, pol, pha, rate};
  endfunction

  task automatic clear_flag();
    logic [7:0] s;
    rd(2'd1, s);
    rd(2'd2, s);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk({sck_o, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 pins reset",
        {sck_o, sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(2'd0, 8'h5B);
    rd(2'd0, v); chk(v == 8'h5B, "R2 ctrl readback", v, 8'h5B);
    wr(2'd0, 8'hA4);
    rd(2'd0, v); chk(v == 8'hA4, "R2 ctrl readback", v, 8'hA4);
  endtask

  task automatic t_master(input logic pol, input logic pha, input logic [2:0] rate,
                          input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] s, d;
    wr(2'd0, cw(1'b0, 1'b1, pol, pha, rate));
    repeat (2) @(negedge clk);
    bm_cpol = pol; bm_cpha = pha; bm_prev = sck_o; bm_edges = 0; bm_rx = 8'd0;
    if (!pha) begin bm_out = stx[7]; bm_tx = stx << 1; end
    else      begin bm_out = 1'b0;   bm_tx = stx;      end
    bm_en = 1'b1;
    chk(sck_o == pol, "R4 idle level", sck_o, pol);
    wr(2'd2, tx);
    repeat (16 * (1 << rate) + 8) @(negedge clk);
    bm_en = 1'b0;
    chk(bm_edges == 16, "R4 edge count", bm_edges, 16);
    chk(sck_o == pol, "R4 idle after", sck_o, pol);
    if (pha) chk(bm_rx == tx, "R6 mosi byte", bm_rx, tx);
    else     chk(bm_rx == tx, "R5 mosi byte", bm_rx, tx);
    rd(2'd1, s); chk(s == 8'h80, "R7 flag set", s, 8'h80);
    rd(2'd2, d);
    if (pha) chk(d == stx, "R6 R13 miso byte", d, stx);
    else     chk(d == stx, "R5 R13 miso byte", d, stx);
    rd(2'd1, s); chk(s == 8'h00, "R7 flag cleared", s, 0);
  endtask

  task automatic t_rate(input logic [2:0] code);
    int n, half;
    half = (code > 3'd6) ? 64 : (1 << code);
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, code));
    repeat (2) @(negedge clk);
    wr(2'd2, 8'h5A);
    n = 0;
    while (sck_o == 1'b0 && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (sck_o == 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n == half, "R3 half period", n, half);
    repeat (16 * half + 8) @(negedge clk);
    clear_flag();
  endtask

  task automatic t_flag();
    logic [7:0] s;
    t_master_start(8'h11);
    rd(2'd2, s);
    rd(2'd1, s); chk(s == 8'h80, "R7 data access alone keeps flag", s, 8'h80);
    rd(2'd2, s);
    rd(2'd1, s); chk(s == 8'h00, "R7 status then data clears", s, 0);
  endtask

  task automatic t_master_start(input logic [7:0] tx);
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    repeat (2) @(negedge clk);
    wr(2'd2, tx);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_busy();
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b1, 3'd2));
    repeat (2) @(negedge clk);
    bm_cpol = 1'b0; bm_cpha = 1'b1; bm_prev = sck_o; bm_edges = 0; bm_rx = 8'd0;
    bm_tx = 8'h3C; bm_out = 1'b0; bm_en = 1'b1;
    wr(2'd2, 8'hB2);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'h4D);
    repeat (16 * 4 + 40) @(negedge clk);
    bm_en = 1'b0;
    chk(bm_rx == 8'hB2, "R8 byte in flight kept", bm_rx, 8'hB2);
    chk(bm_edges == 16, "R8 no second transfer", bm_edges, 16);
    clear_flag();
  endtask

  task automatic t_slave(input logic pol, input logic pha, input logic off, input logic use_ss,
                         input logic [7:0] dtx, input logic [7:0] btx, input logic active,
                         input logic [7:0] prev_rx, input string req);
    logic [7:0] brx, s, d;
    int oe_bad;
    brx = 8'd0; oe_bad = 0;
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    sck_i = pol; ss_n_i = 1'b1; mosi_i = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd0, cw(off, 1'b0, pol, pha, 3'd0));
    repeat (4) @(negedge clk);
    wr(2'd2, dtx);
    if (use_ss) ss_n_i = 1'b0;
    if (!pha) mosi_i = btx[7];
    repeat (SHALF) @(negedge clk);
    if (active && !pha) chk(miso_o == dtx[7], "R10 first bit before edge", miso_o, dtx[7]);
    for (int i = 7; i >= 0; i--) begin
      if (miso_oe != active) oe_bad++;
      if (!pha) begin
        brx = {brx[6:0], miso_o};
        sck_i = ~pol;
        repeat (SHALF) @(negedge clk);
        sck_i = pol;
        if (i > 0) mosi_i = btx[i-1];
        repeat (SHALF) @(negedge clk);
      end else begin
        sck_i = ~pol;
        mosi_i = btx[i];
        repeat (SHALF) @(negedge clk);
        brx = {brx[6:0], miso_o};
        sck_i = pol;
        repeat (SHALF) @(negedge clk);
      end
    end
    chk(oe_bad == 0, {req, " miso enable"}, oe_bad, 0);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd1, s);
    if (active) begin
      chk(brx == dtx, {req, " slave reply"}, brx, dtx);
      chk(s == 8'h80, {req, " R7 flag"}, s, 8'h80);
      rd(2'd2, d); chk(d == btx, {req, " R13 received"}, d, btx);
      rd(2'd1, s); chk(s == 8'h00, {req, " R7 cleared"}, s, 0);
    end else begin
      chk(s == 8'h00, {req, " no flag"}, s, 0);
      rd(2'd2, d); chk(d == prev_rx, {req, " R13 data unchanged"}, d, prev_rx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl();
    t_master(1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C);
    t_master(1'b1, 1'b0, 3'd1, 8'hC3, 8'h81);
    t_master(1'b0, 1'b1, 3'd2, 8'h69, 8'hF0);
    t_master(1'b1, 1'b1, 3'd0, 8'h0F, 8'hE7);
    t_rate(3'd0);
    t_rate(3'd3);
    t_rate(3'd7);
    t_flag();
    t_busy();
    t_slave(1'b0, 1'b0, 1'b0, 1'b1, 8'hD2, 8'h4B, 1'b1, 8'h00, "R9 slave phase0");
    t_slave(1'b1, 1'b1, 1'b0, 1'b1, 8'h3E, 8'hB5, 1'b1, 8'h00, "R9 slave phase1");
    t_slave(1'b0, 1'b1, 1'b1, 1'b0, 8'h77, 8'h18, 1'b1, 8'h00, "R11 select off");
    t_slave(1'b0, 1'b0, 1'b1, 1'b0, 8'h99, 8'h66, 1'b0, 8'h18, "R12 select off ignored");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule